// File: doc/BRIEF.md
# Byte-serial register command deserializer

This block turns a stream of bytes on an 8-bit bus into register writes. A command starts with a byte marked by a first-byte strobe. The next bytes follow on consecutive cycles with the strobe low. The first two bytes form a 16-bit address, low byte first. The remaining bytes form the data word, least significant byte first.

The block compares the assembled address with a base value under a mask. When they match, it issues a one-cycle write enable. Alongside the pulse it presents the low bits of the address as a local register index, together with the data word. Commands for other address windows pass by with no effect.

The parameter `NUM_BYTES` sets the command length and therefore the data width (`8*(NUM_BYTES-2)`). With the defaults, a 6-byte command carries 32 data bits, and the block decodes 16 registers at base 0x200 with mask 0x3F0.

Top module: `regcmd_deser`

## Requirements
- R1: After reset, `wr_en`, `wr_addr` and `wr_data` are all zero and the block is idle. Bytes presented without a preceding strobe produce no write.
- R2: The first byte of a command (the one marked by `cmd_first`) is address bits [7:0], and the second byte is address bits [15:8].
- R3: Data bytes are assembled little-endian: the third command byte lands in `wr_data[7:0]`, the fourth in [15:8], and so on up to the last byte.
- R4: For a matching command, `wr_en` is high for exactly one cycle, namely the cycle after the last byte is sampled.
- R5: A command whose address does not match produces no `wr_en`. In that case `wr_addr` and `wr_data` keep their previous values.
- R6: An address matches when `(addr & MASK) == (BASE & MASK)`; bits outside the mask are ignored. On a match, `wr_addr` is `addr[LOCAL_AW-1:0]`.
- R7: A strobe arriving before the last byte of a command discards the partial command, and a new command starts with that byte as its address-low byte.
- R8: Once a command is complete, further bytes without a strobe are ignored until the next strobe.
- R9: `wr_addr` and `wr_data` change only in a cycle in which `wr_en` is high.
- R10: A new command may start in the cycle right after the last byte of the previous one, and both commands are decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| cmd_byte | input | 8 | Command byte bus |
| cmd_first | input | 1 | High with the first byte of a command |
| wr_en | output | 1 | One-cycle write pulse for a matching command |
| wr_addr | output | LOCAL_AW | Local register index |
| wr_data | output | 8*(NUM_BYTES-2) | Assembled data word |

## Verification
The assertions assume that the source drives bytes on consecutive cycles and raises the strobe only with a first byte. The single-cycle pulse property relies on every command being at least three bytes long, which keeps any two write pulses at least three cycles apart. The bench changes inputs only on falling edges and never holds the strobe for more than one cycle. Aborts are produced by re-raising the strobe part-way through a command, which is a legal restart rather than a glitch.

// File: rtl/regcmd_deser.sv
`timescale 1ns/1ps
module regcmd_deser #(
  parameter int          NUM_BYTES = 6,
  parameter logic [15:0] BASE      = 16'h0200,
  parameter logic [15:0] MASK      = 16'h03F0,
  parameter int          LOCAL_AW  = 4,
  localparam int         DATA_W    = 8 * (NUM_BYTES - 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          cmd_byte,
  input  logic                cmd_first,
  output logic                wr_en,
  output logic [LOCAL_AW-1:0] wr_addr,
  output logic [DATA_W-1:0]   wr_data
);
  localparam int CW      = $clog2(NUM_BYTES);
  localparam int LASTIDX = NUM_BYTES - 1;

  logic              active;
  logic [CW-1:0]     idx;
  logic [15:0]       addr_q;
  logic [DATA_W-1:0] data_q, data_nx;
  logic              take, last_byte, hit;

  assign take      = active && !cmd_first;
  assign last_byte = take && (idx == CW'(LASTIDX));
  assign hit       = ((addr_q & MASK) == (BASE & MASK));

  always_comb begin
    data_nx = data_q;
    for (int k = 0; k < NUM_BYTES - 2; k++)
      if (take && idx == CW'(k + 2)) data_nx[8*k +: 8] = cmd_byte;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (cmd_first) begin
      active      <= 1'b1;
      idx         <= CW'(1);
      addr_q[7:0] <= cmd_byte;
    end else if (active) begin
      idx    <= idx + 1'b1;
      data_q <= data_nx;
      if (idx == CW'(1)) addr_q[15:8] <= cmd_byte;
      if (last_byte) active <= 1'b0;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= last_byte && hit;
      if (last_byte && hit) begin
        wr_addr <= addr_q[LOCAL_AW-1:0];
        wr_data <= data_nx;
      end
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    active |-> (idx <= CW'(LASTIDX))); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R4
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> ($stable(wr_addr) && $stable(wr_data))); // R9
  AST_NO_STROBE_LAST: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(cmd_first)); // R7
  AST_WE_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(active)); // R8
endmodule

// File: tb/regcmd_deser_tb_top.sv
`timescale 1ns/1ps
module regcmd_deser_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cmd_byte = 8'h00;
  logic        cmd_first = 1'b0;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  regcmd_deser dut_i (
    .clk(clk), .rst(rst), .cmd_byte(cmd_byte), .cmd_first(cmd_first),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic f);
    cmd_byte  = b;
    cmd_first = f;
    @(negedge clk);
  endtask

  task automatic send_cmd(input logic [15:0] a, input logic [31:0] d);
    send_byte(a[7:0], 1'b1);
    send_byte(a[15:8], 1'b0);
    for (int i = 0; i < 4; i++) send_byte(d[8*i +: 8], 1'b0);
  endtask

  task automatic idle_count(input int n, output int pulses);
    pulses = 0;
    cmd_first = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (wr_en) pulses++;
      @(negedge clk);
    end
  endtask

  task automatic expect_write(input logic [3:0] a, input logic [31:0] d, input string req);
    chk(wr_en === 1'b1, req, {31'b0, wr_en}, 32'h1);
    chk(wr_addr === a, req, {28'b0, wr_addr}, {28'b0, a});
    chk(wr_data === d, req, wr_data, d);
  endtask

  task automatic t_reset;
    chk(wr_en === 1'b0, "R1", {31'b0, wr_en}, 0);
    chk(wr_addr === 4'h0, "R1", {28'b0, wr_addr}, 0);
    chk(wr_data === 32'h0, "R1", wr_data, 0);
  endtask

  task automatic t_no_strobe;
    int p;
    send_byte(8'h03, 1'b0); send_byte(8'h02, 1'b0);
    for (int i = 0; i < 4; i++) send_byte(8'h11, 1'b0);
    idle_count(4, p);
    chk(p == 0, "R1", p, 0);
  endtask

  task automatic t_match;
    int p;
    send_cmd(16'h0203, 32'hA1B2C3D4);
    expect_write(4'h3, 32'hA1B2C3D4, "R2 R3 R4");
    cmd_first = 1'b0;
    @(negedge clk);
    chk(wr_en === 1'b0, "R4", {31'b0, wr_en}, 0);
    idle_count(3, p);
    chk(p == 0, "R4", p, 0);
  endtask

  task automatic t_mask;
    send_cmd(16'hFE0A, 32'h01020304);
    expect_write(4'hA, 32'h01020304, "R6");
    send_cmd(16'h020F, 32'hDEADBEEF);
    expect_write(4'hF, 32'hDEADBEEF, "R6");
  endtask

  task automatic t_miss;
    int p;
    send_cmd(16'h0213, 32'h55667788);
    idle_count(4, p);
    chk(p == 0, "R5", p, 0);
    chk(wr_data === 32'hDEADBEEF, "R5 R9", wr_data, 32'hDEADBEEF);
    chk(wr_addr === 4'hF, "R5 R9", {28'b0, wr_addr}, 32'hF);
    send_cmd(16'h0702, 32'h12345678);
    idle_count(3, p);
    chk(p == 0, "R2", p, 0);
  endtask

  task automatic t_abort;
    int p;
    send_byte(8'h05, 1'b1); send_byte(8'h02, 1'b0); send_byte(8'h99, 1'b0);
    send_cmd(16'h0206, 32'hCAFEF00D);
    expect_write(4'h6, 32'hCAFEF00D, "R7");
    idle_count(4, p);
    chk(p == 1, "R7", p, 1);
  endtask

  task automatic t_trailing;
    int p;
    send_cmd(16'h0201, 32'h0BADC0DE);
    expect_write(4'h1, 32'h0BADC0DE, "R8");
    for (int i = 0; i < 6; i++) send_byte(8'h02, 1'b0);
    idle_count(3, p);
    chk(p == 0, "R8", p, 0);
    chk(wr_data === 32'h0BADC0DE, "R8", wr_data, 32'h0BADC0DE);
  endtask

  task automatic t_back2back;
    send_cmd(16'h0208, 32'h11112222);
    expect_write(4'h8, 32'h11112222, "R10");
    send_cmd(16'h0209, 32'h33334444);
    expect_write(4'h9, 32'h33334444, "R10");
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_no_strobe;
    t_match;
    t_mask;
    t_miss;
    t_abort;
    t_trailing;
    t_back2back;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule